// File: doc/BRIEF.md
# Programmable Bit Rate Generator

This block derives a bit-rate clock from one of two sources: the system clock, or the rising edges of an external clock pin sampled on the system clock. A 16-bit time constant, written a byte at a time, sets the divide ratio. A down-counter runs from TC+1 to zero on every source tick and then reloads. At each reload the output toggles. The output is therefore a square wave at source/(2·(TC+2)). For example, a 3.6864 MHz source with TC=190 gives 9600 bit/s.

A clock-factor stage follows the divider. It treats each rising edge of the bit-rate clock as one count of a bit cell, and the cell is 1, 16, 32 or 64 counts long. It emits a one-cycle sample strobe at the middle of the cell: count 8 of 16, 16 of 32, or 32 of 64. In 1x mode it strobes on every bit-rate rising edge. A falling edge on the receive line restarts the cell count, so that the strobe lines up with the middle of a start bit. A receiver uses the strobe to sample asynchronous data.

Top module: `bitrate_gen`

## Requirements
- R1: Reset sets the bit-rate clock low, the strobe low and the time constant to 0. When enabled with TC=0 from the system clock, the output period is 4 clock cycles.
- R2: A write with `tc_lo_we` replaces only bits 7:0 of the time constant. A write with `tc_hi_we` replaces only bits 15:8.
- R3: While enabled, the output toggles once every TC+2 source ticks. With the system clock as source and TC=190, the period is 384 cycles. With TC=46 it is 96 cycles.
- R4: With `src_sel`=0 every system clock cycle is a tick. With `src_sel`=1 a tick is a system clock cycle in which `ext_clk` is sampled high after being sampled low. The duty cycle of `ext_clk` has no effect.
- R5: While `enable` is low, the output and the strobe stay low, the cell count is cleared, and the counter holds TC+1. After `enable` rises, the first rising output edge comes TC+2 ticks later.
- R6: A new time constant takes effect at the next reload, and the half period in progress completes with the old value.
- R7: `factor_sel`=2'b00 selects 1x mode, in which every rising edge of the bit-rate clock produces a strobe.
- R8: `factor_sel` values 2'b01, 2'b10 and 2'b11 select 16, 32 and 64 counts per cell. A strobe is produced only on the rising edge that brings the cell count to half the cell length, so consecutive strobes are 16, 32 or 64 rising edges apart.
- R9: A falling edge on `rx_line` clears the cell count, and this takes precedence over a rising edge in the same cycle. The first strobe then comes on the 8th, 16th or 32nd rising edge after the falling edge.
- R10: The strobe is one cycle wide and is asserted in the same cycle in which the bit-rate clock goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low holds it loaded and idle |
| src_sel | input | 1 | 0: system clock ticks, 1: external pin rising edges |
| ext_clk | input | 1 | External source clock, sampled on clk |
| tc_lo_we | input | 1 | Writes tc_byte into the low byte of the time constant |
| tc_hi_we | input | 1 | Writes tc_byte into the high byte of the time constant |
| tc_byte | input | 8 | Time constant byte data |
| factor_sel | input | 2 | Clock factor: 00=1x, 01=16x, 10=32x, 11=64x |
| rx_line | input | 1 | Receive data line; a falling edge realigns the cell |
| brg_clk | output | 1 | Bit-rate square-wave clock |
| sample_stb | output | 1 | One-cycle mid-cell sample strobe |

## Verification
Every input acts at the first clock edge after it is driven. A tick at that edge reloads the counter or counts it down. The output toggle and any strobe appear at the edge where the counter passes zero, so both outputs are visible one edge after the final tick. A time-constant write reaches the register at that same first edge, but the divider only reads it at its next reload. The bench models this timing in a behavioural reference that is updated at each rising edge. It compares both outputs at every falling edge. The directed checks count falling-edge samples from the driving edge, using exactly these latencies: TC+2 cycles to the first rising output edge, and 8, 16 or 32 rising edges from a receive-line fall to the strobe.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic [1:0] {
        FACT_X1  = 2'b00,
        FACT_X16 = 2'b01,
        FACT_X32 = 2'b10,
        FACT_X64 = 2'b11
    } factor_e;
endpackage

// File: rtl/brg_tc_reg.sv
module brg_tc_reg #(
    parameter int TC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we_i,
    input  logic              hi_we_i,
    input  logic [TC_W/2-1:0] byte_i,
    output logic [TC_W-1:0]   tc_o
);
    localparam int HALF = TC_W / 2;

    typedef struct packed {
        logic [TC_W-1:0] tc;
    } tc_st_t;

    tc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we_i) st_d.tc[HALF-1:0]    = byte_i;
        if (hi_we_i) st_d.tc[TC_W-1:HALF] = byte_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc_o = st_q.tc;

    assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we_i && !hi_we_i |=> st_q.tc[TC_W-1:HALF] == $past(st_q.tc[TC_W-1:HALF]));
    assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we_i && !lo_we_i |=> st_q.tc[HALF-1:0] == $past(st_q.tc[HALF-1:0]));
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            src_sel_i,
    input  logic            ext_clk_i,
    input  logic [TC_W-1:0] tc_i,
    output logic            brg_o,
    output logic            rise_o
);
    localparam int CNT_W = TC_W + 1;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             brg;
        logic             ext_prev;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic             tick;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = {1'b0, tc_i} + ONE_C;
    assign tick       = src_sel_i ? (ext_clk_i & ~st_q.ext_prev) : 1'b1;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_clk_i;
        rise_o        = 1'b0;
        if (!en_i) begin
            st_d.cnt = reload_val;
            st_d.brg = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.brg = ~st_q.brg;
                st_d.cnt = reload_val;
                rise_o   = ~st_q.brg;
            end else begin
                st_d.cnt = st_q.cnt - ONE_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brg_o = st_q.brg;

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.brg);
    assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !tick |=> $stable(st_q.brg));
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && tick && st_q.cnt == '0 |=> st_q.cnt == $past(reload_val));
endmodule

// File: rtl/brg_cell.sv
module brg_cell
    import brg_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_i,
    input  factor_e factor_i,
    input  logic    rise_i,
    input  logic    rx_i,
    output logic    stb_o
);
    localparam logic [CELL_W-1:0] FULL  = '1;
    localparam logic [CELL_W-1:0] ONE_C = CELL_W'(1);

    typedef struct packed {
        logic [CELL_W-1:0] cnt;
        logic              stb;
        logic              rx_prev;
    } cell_st_t;

    cell_st_t          st_d, st_q;
    logic [CELL_W-1:0] mask;
    logic [CELL_W-1:0] half;
    logic [CELL_W-1:0] nxt;
    logic              fall;

    always_comb begin
        case (factor_i)
            FACT_X16: mask = FULL >> 2;
            FACT_X32: mask = FULL >> 1;
            FACT_X64: mask = FULL;
            default:  mask = '0;
        endcase
    end

    assign half = (mask >> 1) + ONE_C;
    assign nxt  = (st_q.cnt + ONE_C) & mask;
    assign fall = st_q.rx_prev & ~rx_i;

    always_comb begin
        st_d         = st_q;
        st_d.rx_prev = rx_i;
        st_d.stb     = 1'b0;
        if (!en_i || fall) begin
            st_d.cnt = '0;
        end else if (rise_i) begin
            if (factor_i == FACT_X1) begin
                st_d.cnt = '0;
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = nxt;
                st_d.stb = (nxt == half);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, stb: 1'b0, rx_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign stb_o = st_q.stb;

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0) && !st_q.stb);
    assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |=> !st_q.stb);
    assert_fall_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> st_q.cnt == '0 && !st_q.stb);
endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
    import brg_pkg::*;
#(
    parameter int TC_W   = 16,
    parameter int CELL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              src_sel,
    input  logic              ext_clk,
    input  logic              tc_lo_we,
    input  logic              tc_hi_we,
    input  logic [TC_W/2-1:0] tc_byte,
    input  logic [1:0]        factor_sel,
    input  logic              rx_line,
    output logic              brg_clk,
    output logic              sample_stb
);
    logic [TC_W-1:0] tc_val;
    logic            rise;
    factor_e         factor;

    assign factor = factor_e'(factor_sel);

    brg_tc_reg #(.TC_W(TC_W)) tc_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we_i (tc_lo_we),
        .hi_we_i (tc_hi_we),
        .byte_i  (tc_byte),
        .tc_o    (tc_val)
    );

    brg_divider #(.TC_W(TC_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable),
        .src_sel_i (src_sel),
        .ext_clk_i (ext_clk),
        .tc_i      (tc_val),
        .brg_o     (brg_clk),
        .rise_o    (rise)
    );

    brg_cell #(.CELL_W(CELL_W)) cell_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .factor_i (factor),
        .rise_i   (rise),
        .rx_i     (rx_line),
        .stb_o    (sample_stb)
    );

    assert_stb_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $rose(brg_clk));
endmodule

// File: tb/bitrate_gen_tb_top.sv
module bitrate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       src_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic       tc_lo_we = 1'b0;
    logic       tc_hi_we = 1'b0;
    logic [7:0] tc_byte = 8'h00;
    logic [1:0] factor_sel = 2'b00;
    logic       rx_line = 1'b1;
    logic       brg_clk;
    logic       sample_stb;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit ext_run = 1'b0;
    int ext_ph = 0;

    always #10 clk = ~clk;

    bitrate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
        .ext_clk(ext_clk), .tc_lo_we(tc_lo_we), .tc_hi_we(tc_hi_we),
        .tc_byte(tc_byte), .factor_sel(factor_sel), .rx_line(rx_line),
        .brg_clk(brg_clk), .sample_stb(sample_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced at each rising edge
    int m_tc = 0, m_cnt = 0, m_brg = 0, m_cell = 0, m_stb = 0;
    int m_ext_prev = 0, m_rx_prev = 1;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tc = 0; m_cnt = 0; m_brg = 0; m_cell = 0; m_stb = 0;
            m_ext_prev = 0; m_rx_prev = 1;
        end else begin
            int tick, fall, rise, n;
            tick = src_sel ? (ext_clk && !m_ext_prev) : 1;
            fall = m_rx_prev && !rx_line;
            n = (factor_sel == 2'b00) ? 1 : (8 << factor_sel);
            rise = 0;
            m_stb = 0;
            if (!enable) begin
                m_cnt = m_tc + 1; m_brg = 0; m_cell = 0;
            end else begin
                if (tick) begin
                    if (m_cnt == 0) begin
                        m_brg = 1 - m_brg; rise = m_brg; m_cnt = m_tc + 1;
                    end else m_cnt = m_cnt - 1;
                end
                if (fall) m_cell = 0;
                else if (rise) begin
                    if (n == 1) begin m_cell = 0; m_stb = 1; end
                    else begin
                        m_cell = (m_cell + 1) % n;
                        m_stb = (m_cell == n / 2);
                    end
                end
            end
            m_ext_prev = ext_clk;
            m_rx_prev = rx_line;
            if (tc_lo_we) m_tc = (m_tc & 32'hFF00) | tc_byte;
            if (tc_hi_we) m_tc = (m_tc & 32'h00FF) | (int'(tc_byte) << 8);
        end
    end

    // per-cycle comparison against the model (R3 R4 R5 R6 R8 R9)
    always @(negedge clk) begin
        if (rst_n) begin
            check(brg_clk == m_brg[0], "R3 model brg_clk", brg_clk, m_brg);
            check(sample_stb == m_stb[0], "R8 model sample_stb", sample_stb, m_stb);
        end
    end

    // external clock: high one cycle in five (20% duty)
    always @(negedge clk) begin
        if (ext_run) begin
            ext_ph = (ext_ph + 1) % 5;
            ext_clk = (ext_ph == 0);
        end else ext_clk = 1'b0;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr_lo(input logic [7:0] b);
        tc_byte = b; tc_lo_we = 1'b1;
        @(negedge clk);
        tc_lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [7:0] b);
        tc_byte = b; tc_hi_we = 1'b1;
        @(negedge clk);
        tc_hi_we = 1'b0;
    endtask

    task automatic wait_rise();
        logic p;
        do begin p = brg_clk; @(negedge clk); end while (!(brg_clk && !p));
    endtask

    task automatic measure_period(output int n);
        logic p;
        wait_rise();
        n = 0;
        do begin p = brg_clk; @(negedge clk); n++; end while (!(brg_clk && !p));
    endtask

    task automatic rises_to_stb(output int n);
        logic p;
        n = 0;
        do begin
            p = brg_clk; @(negedge clk);
            if (brg_clk && !p) n++;
        end while (!sample_stb && n < 200);
    endtask

    initial begin
        int n, st, ri;
        repeat (3) @(negedge clk);
        check(brg_clk == 1'b0, "R1 reset brg_clk", brg_clk, 0);
        check(sample_stb == 1'b0, "R1 reset sample_stb", sample_stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        measure_period(n);
        check(n == 4, "R1 period with reset TC", n, 4);

        enable = 1'b0;
        wr_lo(8'hBE); wr_hi(8'h00);
        enable = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!brg_clk);
        check(n == 192, "R5 first rise after enable", n, 192);
        measure_period(n);
        check(n == 384, "R3 TC=190 period", n, 384);

        // R6: change TC right after a reload; R2 low byte only
        wait_rise();
        wr_lo(8'h2E);
        n = 1;
        while (brg_clk) begin @(negedge clk); n++; end
        check(n == 192, "R6 old half period completes", n, 192);
        n = 0;
        do begin @(negedge clk); n++; end while (!brg_clk);
        check(n == 48, "R6 new half period", n, 48);
        measure_period(n);
        check(n == 96, "R2 R3 TC=46 period", n, 96);

        // R4: external source, 20% duty
        enable = 1'b0;
        src_sel = 1'b1;
        wr_lo(8'h02);
        ext_run = 1'b1;
        enable = 1'b1;
        measure_period(n);
        check(n == 40, "R4 external source period", n, 40);
        enable = 1'b0;
        @(negedge clk);
        check(brg_clk == 1'b0, "R5 disabled output low", brg_clk, 0);
        ext_run = 1'b0; src_sel = 1'b0;
        wr_lo(8'h01);

        // R7: 1x mode
        enable = 1'b1;
        wait_rise();
        st = 0; ri = 0;
        for (int i = 0; i < 30; i++) begin
            logic p;
            p = brg_clk; @(negedge clk);
            if (brg_clk && !p) ri++;
            if (sample_stb) st++;
        end
        check(st == 5 && ri == 5, "R7 one strobe per rise", st, 5);

        // R8 R9 R10: 16x, 32x, 64x
        for (int f = 1; f < 4; f++) begin
            enable = 1'b0;
            factor_sel = 2'(f);
            @(negedge clk);
            enable = 1'b1;
            wait_rise();
            rx_line = 1'b0;
            @(negedge clk);
            rx_line = 1'b1;
            rises_to_stb(n);
            check(n == (4 << f), "R9 rises from fall to strobe", n, 4 << f);
            @(negedge clk);
            check(sample_stb == 1'b0, "R10 strobe one cycle", sample_stb, 0);
            rises_to_stb(n);
            check(n == (8 << f), "R8 rises between strobes", n, 8 << f);
        end

        enable = 1'b0;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule